// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block is a cycle-accurate model of a synchronous static memory. It has a two-bit burst counter and flow-through read data. Each word is 36 bits wide and is split into four byte lanes of 9 bits. The full-size part uses 18 address bits, which gives 256K words. The parameter `ADDR_W` sets the depth. Its default is 10, so that elaboration stays small, and setting it to 18 gives the full part.

Two active-low address strobes start an access on a rising clock edge:
- The host-side strobe (`host_strb_n`) wins when both are low. On its load cycle the write controls are ignored.
- The controller-side strobe (`ctl_strb_n`) can also write the loaded address in its load cycle. Asserting it in the middle of a burst abandons the current burst and starts a new one.

After a load, the active-low advance input `burst_go_n` steps the internal address or holds it. The address steps through the four words of an aligned group and then wraps to the start of the same group. Three chip enables gate every strobe.

Read data for the current internal address is presented combinationally on `rd_data` in the cycle after the edge. There is no output register. `bus_drive` stands in for the tri-state enable of the data pins: when it is low, the pins are at high impedance.

Top module: `bsr_sram`

## Requirements
- R1: When either strobe is low at an edge and the chip is selected, the internal address becomes `addr`. From that cycle on, `rd_data` shows the stored word at that address.
- R2: In a cycle with both strobes high, an active burst and `burst_go_n` low, the edge advances the internal address. The two low bits increase by one modulo 4 and the upper bits do not change. From load address A the order is therefore A, then A with low bits +1, +2, +3, and back to A.
- R3: In a cycle with both strobes high and `burst_go_n` high, the internal address does not change and the burst is suspended for that cycle.
- R4: A low `ctl_strb_n` during a burst loads `addr` and restarts the burst from that address.
- R5: On an edge where `host_strb_n` is low, no memory bit changes, whatever the write inputs are.
- R6: On an edge where `ctl_strb_n` loads an address, that address is written only if `burst_go_n` is high.
- R7: The chip is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. These are sampled only together with a strobe. A strobe seen while the chip is not selected ends the burst: `bus_drive` goes low, and until the next load no cycle writes or advances.
- R8: Lane n covers data bits [9n+8:9n]. The lane is written when `wr_all_n` is 0, or when both `wr_byte_n` and `lane_wr_n[n]` are 0. Any other lane keeps its contents.
- R9: `bus_drive` is 1 only when all three hold: the burst is active, `rd_en_n` is 0, and the preceding edge wrote no lane. It is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the access state |
| addr | input | ADDR_W | Word address sampled with a strobe |
| host_strb_n | input | 1 | Host-side address strobe, active low, ignores write controls |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| burst_go_n | input | 1 | Burst advance, active low; high suspends |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_byte_n | input | 1 | Byte-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| rd_en_n | input | 1 | Read output enable, active low |
| wr_data | input | LANES*LANE_W | Write data |
| rd_data | output | LANES*LANE_W | Flow-through read data of the internal address |
| bus_drive | output | 1 | Data pins driven when 1, high impedance when 0 |

## Verification
The checker module tests a set of rules on every cycle. It checks the address load on a selected strobe and the in-group increment with its upper bits held. It also checks that the address stays put on a suspend cycle. It checks that no write is issued on a host-strobe edge, on a controller-strobe edge with advance low, or while the chip is deselected. Finally, it checks that the bus is never driven with `rd_en_n` high or just after a write.

Only the bench scenarios show whether the stored data are right, because that needs a memory model. These scenarios cover:
- the wrap order from every start offset of a group;
- lane merging under all sixteen byte masks;
- the eight chip-enable combinations;
- the fact that ignored writes leave every word untouched.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int LANES_DEF  = 4;
    localparam int LANE_W_DEF = 9;
    localparam int BURST_W    = 2;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_LOAD_H = 2'd1,
        ACC_LOAD_C = 2'd2,
        ACC_CONT   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      desel;
        logic      step;
        logic      wr_ok;
    } acc_ctl_t;

    function automatic logic [BURST_W-1:0] burst_next(input logic [BURST_W-1:0] c);
        return c + BURST_W'(1);
    endfunction

    function automatic logic chip_selected(input logic a_n, input logic b, input logic c_n);
        return ~a_n & b & ~c_n;
    endfunction

endpackage

// File: rtl/bsr_access_decode.sv
module bsr_access_decode
    import bsr_pkg::*;
(
    input  logic     host_strb_n,
    input  logic     ctl_strb_n,
    input  logic     burst_go_n,
    input  logic     sel_a_n,
    input  logic     sel_b,
    input  logic     sel_c_n,
    input  logic     sel_q,
    output acc_ctl_t ctl
);

    logic chip_on;

    always_comb begin
        chip_on   = chip_selected(sel_a_n, sel_b, sel_c_n);
        ctl.kind  = ACC_IDLE;
        ctl.desel = 1'b0;
        if (!host_strb_n) begin
            ctl.kind  = chip_on ? ACC_LOAD_H : ACC_IDLE;
            ctl.desel = ~chip_on;
        end else if (!ctl_strb_n) begin
            ctl.kind  = chip_on ? ACC_LOAD_C : ACC_IDLE;
            ctl.desel = ~chip_on;
        end else if (sel_q) begin
            ctl.kind  = ACC_CONT;
        end
        ctl.step  = (ctl.kind == ACC_CONT) & ~burst_go_n;
        ctl.wr_ok = (ctl.kind == ACC_CONT) | ((ctl.kind == ACC_LOAD_C) & burst_go_n);
    end

endmodule

// File: rtl/bsr_burst_addr.sv
module bsr_burst_addr
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_go,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              sel_q,
    output logic              wr_q
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nxt;
    logic [HI_W-1:0]    base_hi;
    logic [BURST_W-1:0] base_lo;

    assign base_hi  = base_q[ADDR_W-1:BURST_W];
    assign base_lo  = base_q[BURST_W-1:0];
    assign cnt_nxt  = ctl.step ? burst_next(cnt_q) : cnt_q;
    assign cur_addr = {base_hi, base_lo + cnt_q};

    always_comb begin
        unique case (ctl.kind)
            ACC_LOAD_H, ACC_LOAD_C: acc_addr = addr;
            ACC_CONT:               acc_addr = {base_hi, base_lo + cnt_nxt};
            default:                acc_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            wr_q <= wr_go;
            unique case (ctl.kind)
                ACC_LOAD_H, ACC_LOAD_C: begin
                    base_q <= addr;
                    cnt_q  <= '0;
                    sel_q  <= 1'b1;
                end
                ACC_CONT: cnt_q <= cnt_nxt;
                default: begin
                    if (ctl.desel) sel_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/bsr_lane_enable.sv
module bsr_lane_enable #(
    parameter int LANES = 4
) (
    input  logic             wr_ok,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] lane_we
);

    for (genvar ln = 0; ln < LANES; ln++) begin : g_en
        assign lane_we[ln] = wr_ok & (~wr_all_n | (~wr_byte_n & ~lane_wr_n[ln]));
    end

endmodule

// File: rtl/bsr_lane_store.sv
module bsr_lane_store #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/bsr_sram.sv
module bsr_sram
    import bsr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    host_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    burst_go_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    rd_en_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    bus_drive
);

    localparam int WORD_W = LANES * LANE_W;

    acc_ctl_t          ctl;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] acc_addr;
    logic              sel_q;
    logic              wr_q;
    logic              wr_go;
    logic [LANES-1:0]  lane_we;
    logic [WORD_W-1:0] rd_word;

    bsr_access_decode u_decode (
        .host_strb_n (host_strb_n),
        .ctl_strb_n  (ctl_strb_n),
        .burst_go_n  (burst_go_n),
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .sel_q       (sel_q),
        .ctl         (ctl)
    );

    bsr_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .addr     (addr),
        .wr_go    (wr_go),
        .cur_addr (cur_addr),
        .acc_addr (acc_addr),
        .sel_q    (sel_q),
        .wr_q     (wr_q)
    );

    bsr_lane_enable #(.LANES(LANES)) u_lanes (
        .wr_ok     (ctl.wr_ok),
        .wr_all_n  (wr_all_n),
        .wr_byte_n (wr_byte_n),
        .lane_wr_n (lane_wr_n),
        .lane_we   (lane_we)
    );

    assign wr_go = |lane_we;

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        bsr_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_store (
            .clk   (clk),
            .we    (lane_we[ln]),
            .waddr (acc_addr),
            .wdata (wr_data[ln*LANE_W +: LANE_W]),
            .raddr (cur_addr),
            .rdata (rd_word[ln*LANE_W +: LANE_W])
        );
    end

    assign rd_data   = rd_word;
    assign bus_drive = sel_q & ~rd_en_n & ~wr_q;

endmodule

// File: rtl/bsr_sram_chk.sv
module bsr_sram_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              host_strb_n,
    input logic              ctl_strb_n,
    input logic              burst_go_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              rd_en_n,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              sel_q,
    input logic              wr_go,
    input logic              bus_drive
);

    logic strobe, picked, no_strobe;
    assign strobe    = ~host_strb_n | ~ctl_strb_n;
    assign picked    = ~sel_a_n & sel_b & ~sel_c_n;
    assign no_strobe = host_strb_n & ctl_strb_n;

    assert_load_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (strobe && picked) |=> (cur_addr == $past(addr)));

    assert_wrap_step_R2: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && sel_q && !burst_go_n) |=>
        ((cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])) &&
         (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)));

    assert_suspend_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && burst_go_n) |=> $stable(cur_addr));

    assert_host_nowrite_R5: assert property (@(posedge clk) disable iff (rst)
        !host_strb_n |-> !wr_go);

    assert_ctl_adv_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
        (host_strb_n && !ctl_strb_n && !burst_go_n) |-> !wr_go);

    assert_desel_release_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe && !picked) |=> !bus_drive);

    assert_idle_nowrite_R7: assert property (@(posedge clk) disable iff (rst)
        (no_strobe && !sel_q) |-> !wr_go);

    assert_drive_needs_oe_R9: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> !rd_en_n);

    assert_no_drive_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !bus_drive);

endmodule

bind bsr_sram bsr_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr        (addr),
    .host_strb_n (host_strb_n),
    .ctl_strb_n  (ctl_strb_n),
    .burst_go_n  (burst_go_n),
    .sel_a_n     (sel_a_n),
    .sel_b       (sel_b),
    .sel_c_n     (sel_c_n),
    .rd_en_n     (rd_en_n),
    .cur_addr    (cur_addr),
    .sel_q       (sel_q),
    .wr_go       (wr_go),
    .bus_drive   (bus_drive)
);

// File: tb/bsr_sram_bench.sv
`timescale 1ns/1ps
module bsr_sram_bench;

    localparam int AW = 10;
    localparam int WW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr;
    logic          host_strb_n, ctl_strb_n, burst_go_n;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          wr_all_n, wr_byte_n;
    logic [3:0]    lane_wr_n;
    logic          rd_en_n;
    logic [WW-1:0] wr_data;
    logic [WW-1:0] rd_data;
    logic          bus_drive;

    always #4 clk = ~clk;

    bsr_sram #(.ADDR_W(AW)) u_bsr_sram (
        .clk(clk), .rst(rst), .addr(addr),
        .host_strb_n(host_strb_n), .ctl_strb_n(ctl_strb_n), .burst_go_n(burst_go_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
        .rd_en_n(rd_en_n), .wr_data(wr_data), .rd_data(rd_data), .bus_drive(bus_drive)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [WW-1:0] exp_mem [1 << AW];

    function automatic logic [WW-1:0] pat(input int a, input int k);
        logic [WW-1:0] v;
        v = WW'(a) * 36'd40503 + WW'(k) * 36'd977;
        return v ^ 36'h9A5C31E7B;
    endfunction

    task automatic chk(input string tag, input logic [WW-1:0] got, input logic [WW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_drv(input string tag, input logic exp);
        chk(tag, {35'd0, bus_drive}, {35'd0, exp});
    endtask

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic quiet;
        host_strb_n = 1'b1; ctl_strb_n = 1'b1; burst_go_n = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = 4'hF;
        rd_en_n = 1'b0; wr_data = '0; addr = '0;
    endtask

    task automatic host_load(input int a);
        quiet;
        host_strb_n = 1'b0;
        addr = AW'(a);
        tick;
        quiet;
    endtask

    task automatic ctl_write(input int a, input logic [WW-1:0] d);
        quiet;
        ctl_strb_n = 1'b0; addr = AW'(a); wr_all_n = 1'b0; wr_data = d;
        tick;
        exp_mem[a] = d;
        quiet;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
    end

    initial begin
        logic [WW-1:0] e;
        logic [WW-1:0] d;
        logic [3:0]    mk;
        quiet;
        repeat (3) tick;
        chk_drv("R9 drive low in reset", 1'b0);
        rst = 1'b0;
        tick;
        chk_drv("R9 drive low after reset", 1'b0);

        // fill groups 0..15: ctl load writes word 0, advances write 1..3 (R6, R2)
        for (int g = 0; g < 16; g++) begin
            quiet;
            ctl_strb_n = 1'b0; addr = AW'(4*g); wr_all_n = 1'b0; wr_data = pat(4*g, 0);
            rd_en_n = 1'b1;
            tick;
            exp_mem[4*g] = pat(4*g, 0);
            for (int i = 1; i < 4; i++) begin
                ctl_strb_n = 1'b1; burst_go_n = 1'b0; wr_data = pat(4*g + i, 0);
                tick;
                exp_mem[4*g + i] = pat(4*g + i, 0);
            end
        end
        quiet;

        // read bursts from every offset of every group (R1, R2)
        for (int g = 0; g < 16; g++) begin
            for (int s = 0; s < 4; s++) begin
                host_load(4*g + s);
                chk("R1 loaded word", rd_data, exp_mem[4*g + s]);
                chk_drv("R1 read drives bus", 1'b1);
                for (int i = 1; i <= 4; i++) begin
                    burst_go_n = 1'b0;
                    tick;
                    chk("R2 wrap order", rd_data, exp_mem[4*g + ((s + i) % 4)]);
                end
                quiet;
            end
        end

        // suspend (R3)
        host_load(9);
        tick;
        chk("R3 suspend holds", rd_data, exp_mem[9]);
        burst_go_n = 1'b0; tick;
        chk("R3 resume advances", rd_data, exp_mem[10]);
        burst_go_n = 1'b1; tick; tick;
        chk("R3 suspend twice", rd_data, exp_mem[10]);

        // controller strobe restarts mid-burst (R4)
        host_load(20);
        burst_go_n = 1'b0; tick;
        chk("R4 before restart", rd_data, exp_mem[21]);
        ctl_strb_n = 1'b0; addr = AW'(37); tick;
        chk("R4 restarted at new address", rd_data, exp_mem[37]);
        ctl_strb_n = 1'b1; tick;
        chk("R4 continues new burst", rd_data, exp_mem[38]);
        quiet;

        // host strobe ignores write controls (R5)
        quiet;
        host_strb_n = 1'b0; addr = AW'(5); wr_all_n = 1'b0; wr_byte_n = 1'b0;
        lane_wr_n = 4'h0; wr_data = ~exp_mem[5];
        tick;
        chk("R5 host load no write", rd_data, exp_mem[5]);
        chk_drv("R5 no write so bus driven", 1'b1);
        quiet;
        host_load(5);
        chk("R5 word intact", rd_data, exp_mem[5]);

        // all 16 byte masks on one word (R8)
        ctl_write(100, pat(100, 1));
        for (int m = 0; m < 16; m++) begin
            mk = 4'(m);
            d  = pat(100, 20 + m);
            host_load(100);
            wr_byte_n = 1'b0; lane_wr_n = ~mk; wr_data = d;
            tick;
            e = exp_mem[100];
            for (int ln = 0; ln < 4; ln++)
                if (mk[ln]) e[ln*9 +: 9] = d[ln*9 +: 9];
            exp_mem[100] = e;
            host_load(100);
            chk("R8 lane mask merge", rd_data, exp_mem[100]);
        end
        host_load(100);
        wr_byte_n = 1'b1; lane_wr_n = 4'h0; wr_data = pat(100, 50);
        tick;
        host_load(100);
        chk("R8 byte qualifier off", rd_data, exp_mem[100]);
        host_load(100);
        wr_all_n = 1'b0; wr_data = pat(100, 51);
        tick;
        exp_mem[100] = pat(100, 51);
        host_load(100);
        chk("R8 global write all lanes", rd_data, exp_mem[100]);

        // ctl load with advance low does not write (R6)
        quiet;
        ctl_strb_n = 1'b0; addr = AW'(100); burst_go_n = 1'b0; wr_all_n = 1'b0;
        wr_data = pat(100, 60);
        tick;
        quiet;
        host_load(100);
        chk("R6 no write with advance low", rd_data, exp_mem[100]);

        // chip enable combinations (R7)
        ctl_write(200, pat(200, 2));
        for (int c = 0; c < 8; c++) begin
            ctl_write(300 + c, pat(300 + c, 3));
            host_load(200);
            sel_a_n = c[0]; sel_b = c[1]; sel_c_n = c[2];
            ctl_strb_n = 1'b0; addr = AW'(300 + c); wr_all_n = 1'b0;
            wr_data = pat(300 + c, 4);
            tick;
            if (c == 2) exp_mem[300 + c] = pat(300 + c, 4);
            chk_drv("R7 bus not driven", 1'b0);
            quiet;
            wr_all_n = 1'b0; wr_data = pat(300 + c, 5);
            tick;
            if (c == 2) exp_mem[300 + c] = pat(300 + c, 5);
            quiet;
            host_load(300 + c);
            chk("R7 target word", rd_data, exp_mem[300 + c]);
            host_load(200);
            chk("R7 previous word", rd_data, exp_mem[200]);
        end

        // output enable and write turnaround (R9)
        quiet;
        host_strb_n = 1'b0; addr = AW'(40); rd_en_n = 1'b1;
        tick;
        chk_drv("R9 oe high no drive", 1'b0);
        rd_en_n = 1'b0;
        #1;
        chk_drv("R9 oe low drives", 1'b1);
        chk("R9 data with oe", rd_data, exp_mem[40]);
        host_load(41);
        wr_all_n = 1'b0; wr_data = pat(41, 7);
        tick;
        exp_mem[41] = pat(41, 7);
        chk_drv("R9 no drive after write", 1'b0);
        quiet;
        tick;
        chk_drv("R9 drive resumes", 1'b1);
        chk("R9 written data read", rd_data, exp_mem[41]);

        summary;
    end

endmodule